// File: doc/BRIEF.md
# Trigger Event Scaler Bank

This block keeps nine event counters for a coincidence trigger system. One counter tallies the combined logic trigger. The other eight tally the separate coincidence results of the X and Y detector planes, one counter for each fold level. Each counter advances by one on each rising edge of its input pulse, but only after counting has been switched on. A pulse that stays high for many clocks still counts only once.

Software reaches the bank through a crate-style command port. Each command carries a station-select bit, a 4-bit sub-address and a 5-bit function code. Read commands return a 16-bit word at once on `rd_data` and raise `q_resp`. The 24-bit trigger count is read as two words. Clear commands zero one counter or all of them, and a separate command turns counting on. An active-low asynchronous reset and the crate initialise input both return the bank to its idle state.

Top module: `trig_scaler_bank`

## Requirements
- R1: Each plane counter (16 bits) and the trigger counter (24 bits) adds one for every rising edge seen on its input (`plane_in[i]` or `trig_in`) while counting is on.
- R2: With function 2, sub-addresses 0 to 7 return plane counters for `plane_in[0]` to `plane_in[7]`. Sub-address 14 returns trigger count bits 15:0. Sub-address 15 returns trigger count bits 23:16 in bits 7:0, with bits 15:8 read as 0.
- R3: An input held high for several clocks counts once; it counts again only after it has gone low and risen again.
- R4: With function 11, sub-address 0 clears the trigger counter and sub-addresses 1 to 8 clear the plane counter for `plane_in[0]` to `plane_in[7]`; other counters keep their values.
- R5: Function 11 at sub-address 15 clears all nine counters in one command.
- R6: Counting is off after reset and after `init_z`, and inputs are then ignored. Function 17 at sub-address 5 turns counting on.
- R7: Asserting `rst_n` low or pulsing `init_z` for one clock returns all counters to zero.
- R8: A counter at its all-ones value wraps to zero on the next counted edge; the carry from trigger bit 15 reaches bit 16.
- R9: A clear that arrives in the same clock as a counted edge leaves that counter at zero.
- R10: A command acts only when `cmd_valid` and `stn_sel` are both high. A recognised read, clear or enable command raises `q_resp`. Otherwise `q_resp` is 0 and `rd_data` is 0, and an unrecognised read such as sub-address 9 with function 2 returns `q_resp` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_z | input | 1 | Synchronous crate initialise: clears counters and counting enable |
| cmd_valid | input | 1 | Command present this cycle |
| stn_sel | input | 1 | Station select for this module |
| sub_addr | input | 4 | Command sub-address |
| func | input | 5 | Command function code |
| trig_in | input | 1 | Logic trigger pulse |
| plane_in | input | 8 | Plane coincidence pulses |
| rd_data | output | 16 | Read word, valid during a recognised read |
| q_resp | output | 1 | Command accepted response |

## Verification
The corner that is hardest to reach from the ports is counter overflow. The wrap of a 16-bit plane counter, and the matching carry into the high word of the trigger counter, only happen after 65536 counted edges. The stimulus pulses all nine inputs together that many times with counting on. It then reads every plane word back as zero and the trigger high word as one. The case where a clear meets an increment is set up by raising `trig_in` in the same cycle as a clear command for that counter.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned FUNC_W = 5;
  localparam int unsigned DATA_W = 16;

  localparam logic [FUNC_W-1:0] FN_READ   = 5'd2;
  localparam logic [FUNC_W-1:0] FN_CLEAR  = 5'd11;
  localparam logic [FUNC_W-1:0] FN_ENABLE = 5'd17;

  localparam logic [ADDR_W-1:0] SA_TRIG_LO = 4'd14;
  localparam logic [ADDR_W-1:0] SA_TRIG_HI = 4'd15;
  localparam logic [ADDR_W-1:0] SA_CLR_ALL = 4'd15;
  localparam logic [ADDR_W-1:0] SA_ENABLE  = 4'd5;
endpackage

// File: rtl/scaler_cmd_decode.sv
module scaler_cmd_decode
  import scaler_pkg::*;
#(
  parameter int unsigned PLANES = 8
) (
  input  logic              cmd_valid,
  input  logic              stn_sel,
  input  logic [ADDR_W-1:0] sub_addr,
  input  logic [FUNC_W-1:0] func,
  output logic              rd_hit,
  output logic [PLANES:0]   clr_vec,
  output logic              en_set,
  output logic              q_resp
);
  localparam logic [ADDR_W-1:0] PLANE_LIM = ADDR_W'(PLANES);

  logic active;
  logic is_clear;

  assign active   = cmd_valid & stn_sel;
  assign is_clear = active & (func == FN_CLEAR);

  always_comb begin
    rd_hit = active & (func == FN_READ) &
             ((sub_addr < PLANE_LIM) | (sub_addr == SA_TRIG_LO) | (sub_addr == SA_TRIG_HI));
    en_set = active & (func == FN_ENABLE) & (sub_addr == SA_ENABLE);
  end

  // index 0 is the trigger counter, index i+1 the plane counter i
  for (genvar gi = 0; gi <= PLANES; gi++) begin : g_clr
    assign clr_vec[gi] = is_clear & ((sub_addr == ADDR_W'(gi)) | (sub_addr == SA_CLR_ALL));
  end

  assign q_resp = rd_hit | (|clr_vec) | en_set;
endmodule

// File: rtl/scaler_edge_counter.sv
module scaler_edge_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         z_clr,
  input  logic         cnt_en,
  input  logic         clr,
  input  logic         pulse_in,
  output logic [W-1:0] count
);
  logic         prev_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         step;
  logic         cnt_ld;

  always_comb begin
    step   = cnt_en & pulse_in & ~prev_q;
    cnt_ld = z_clr | clr | step;
    if (z_clr | clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= pulse_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ld) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/scaler_read_mux.sv
module scaler_read_mux
  import scaler_pkg::*;
#(
  parameter int unsigned PLANES  = 8,
  parameter int unsigned PLANE_W = 16,
  parameter int unsigned TRIG_W  = 24
) (
  input  logic                            rd_hit,
  input  logic [ADDR_W-1:0]               sub_addr,
  input  logic [TRIG_W-1:0]               trig_cnt,
  input  logic [PLANES-1:0][PLANE_W-1:0]  plane_cnt,
  output logic [DATA_W-1:0]               rd_data
);
  logic [TRIG_W-1:0] trig_hi_sh;
  logic [DATA_W-1:0] sel_word;

  assign trig_hi_sh = trig_cnt >> DATA_W;

  always_comb begin
    sel_word = '0;
    if (sub_addr == SA_TRIG_LO) begin
      sel_word = trig_cnt[DATA_W-1:0];
    end else if (sub_addr == SA_TRIG_HI) begin
      sel_word = trig_hi_sh[DATA_W-1:0];
    end else begin
      for (int i = 0; i < PLANES; i++) begin
        if (sub_addr == ADDR_W'(i)) begin
          sel_word = DATA_W'(plane_cnt[i]);
        end
      end
    end
    rd_data = rd_hit ? sel_word : '0;
  end
endmodule

// File: rtl/trig_scaler_bank.sv
module trig_scaler_bank
  import scaler_pkg::*;
#(
  parameter int unsigned PLANES  = 8,
  parameter int unsigned PLANE_W = 16,
  parameter int unsigned TRIG_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_z,
  input  logic               cmd_valid,
  input  logic               stn_sel,
  input  logic [3:0]         sub_addr,
  input  logic [4:0]         func,
  input  logic               trig_in,
  input  logic [PLANES-1:0]  plane_in,
  output logic [15:0]        rd_data,
  output logic               q_resp
);
  logic [1:0]                     rst_sync_q;
  logic                           rst_core_n;
  logic                           rd_hit;
  logic [PLANES:0]                clr_vec;
  logic                           en_set;
  logic                           en_q;
  logic                           en_d;
  logic [TRIG_W-1:0]              trig_cnt;
  logic [PLANES-1:0][PLANE_W-1:0] plane_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  scaler_cmd_decode #(.PLANES(PLANES)) u_dec (
    .cmd_valid (cmd_valid),
    .stn_sel   (stn_sel),
    .sub_addr  (sub_addr),
    .func      (func),
    .rd_hit    (rd_hit),
    .clr_vec   (clr_vec),
    .en_set    (en_set),
    .q_resp    (q_resp)
  );

  always_comb begin
    en_d = en_q;
    if (init_z) begin
      en_d = 1'b0;
    end else if (en_set) begin
      en_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  scaler_edge_counter #(.W(TRIG_W)) u_trig_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .z_clr    (init_z),
    .cnt_en   (en_q),
    .clr      (clr_vec[0]),
    .pulse_in (trig_in),
    .count    (trig_cnt)
  );

  for (genvar gp = 0; gp < PLANES; gp++) begin : g_plane
    scaler_edge_counter #(.W(PLANE_W)) u_plane_cnt (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .z_clr    (init_z),
      .cnt_en   (en_q),
      .clr      (clr_vec[gp+1]),
      .pulse_in (plane_in[gp]),
      .count    (plane_cnt[gp])
    );
  end

  scaler_read_mux #(
    .PLANES  (PLANES),
    .PLANE_W (PLANE_W),
    .TRIG_W  (TRIG_W)
  ) u_rd_mux (
    .rd_hit    (rd_hit),
    .sub_addr  (sub_addr),
    .trig_cnt  (trig_cnt),
    .plane_cnt (plane_cnt),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/scaler_bank_chk.sv
module scaler_bank_chk #(
  parameter int unsigned PLANES  = 8,
  parameter int unsigned PLANE_W = 16,
  parameter int unsigned TRIG_W  = 24
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           init_z,
  input logic                           cmd_valid,
  input logic                           stn_sel,
  input logic [3:0]                     sub_addr,
  input logic [4:0]                     func,
  input logic                           trig_in,
  input logic [15:0]                    rd_data,
  input logic                           q_resp,
  input logic                           en_q,
  input logic [TRIG_W-1:0]              trig_cnt,
  input logic [PLANES-1:0][PLANE_W-1:0] plane_cnt
);
  logic cmd_on;
  logic trig_clr;
  logic all_clr;
  logic trig_prev;
  logic past_ok;

  assign cmd_on   = cmd_valid && stn_sel;
  assign all_clr  = cmd_on && (func == 5'd11) && (sub_addr == 4'd15);
  assign trig_clr = all_clr || (cmd_on && (func == 5'd11) && (sub_addr == 4'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_prev <= 1'b0;
      past_ok   <= 1'b0;
    end else begin
      trig_prev <= trig_in;
      past_ok   <= 1'b1;
    end
  end

  a_r7_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init_z |=> (trig_cnt == '0) && (plane_cnt == '0));

  a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    all_clr |=> (trig_cnt == '0) && (plane_cnt == '0));

  a_r9_clear_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
    trig_clr |=> (trig_cnt == '0));

  a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !init_z && !trig_clr) |=> $stable(trig_cnt));

  a_r3_level_once: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && trig_in && trig_prev && !init_z && !trig_clr) |=> $stable(trig_cnt));

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && en_q && trig_in && !trig_prev && (trig_cnt == '1) && !init_z && !trig_clr)
      |=> (trig_cnt == '0));

  a_r2_hi_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on && (func == 5'd2) && (sub_addr == 4'd15)) |-> ((rd_data >> (TRIG_W - 16)) == '0));

  a_r10_q_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on && (func == 5'd2) && (sub_addr < 4'd8)) |-> q_resp);

  a_r10_silent_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_on |-> (!q_resp && (rd_data == '0)));
endmodule

bind trig_scaler_bank scaler_bank_chk #(
  .PLANES  (PLANES),
  .PLANE_W (PLANE_W),
  .TRIG_W  (TRIG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .init_z    (init_z),
  .cmd_valid (cmd_valid),
  .stn_sel   (stn_sel),
  .sub_addr  (sub_addr),
  .func      (func),
  .trig_in   (trig_in),
  .rd_data   (rd_data),
  .q_resp    (q_resp),
  .en_q      (en_q),
  .trig_cnt  (trig_cnt),
  .plane_cnt (plane_cnt)
);

// File: tb/trig_scaler_bank_tb.sv
module trig_scaler_bank_tb;
  localparam logic [2:0] OP_PULSE = 3'd0;
  localparam logic [2:0] OP_CLEAR = 3'd1;
  localparam logic [2:0] OP_ENAB  = 3'd2;
  localparam logic [2:0] OP_READ  = 3'd3;
  localparam logic [2:0] OP_HOLD  = 3'd4;
  localparam int NVEC = 25;

  // {op[22:20], addr[19:16], mask[15:7] (bit 8 = trigger), reps[6:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {OP_PULSE, 4'd0,  9'h1FF, 7'd3},   // R6 ignored while off
    {OP_READ,  4'd14, 9'h000, 7'd0},
    {OP_READ,  4'd0,  9'h000, 7'd0},
    {OP_ENAB,  4'd5,  9'h000, 7'd0},
    {OP_PULSE, 4'd0,  9'h101, 7'd5},   // R1
    {OP_PULSE, 4'd0,  9'h088, 7'd2},
    {OP_PULSE, 4'd0,  9'h1FF, 7'd1},
    {OP_READ,  4'd14, 9'h000, 7'd0},   // R2
    {OP_READ,  4'd0,  9'h000, 7'd0},
    {OP_READ,  4'd3,  9'h000, 7'd0},
    {OP_READ,  4'd7,  9'h000, 7'd0},
    {OP_READ,  4'd1,  9'h000, 7'd0},
    {OP_HOLD,  4'd0,  9'h104, 7'd10},  // R3
    {OP_READ,  4'd14, 9'h000, 7'd0},
    {OP_READ,  4'd2,  9'h000, 7'd0},
    {OP_CLEAR, 4'd0,  9'h000, 7'd0},   // R4
    {OP_READ,  4'd14, 9'h000, 7'd0},
    {OP_READ,  4'd0,  9'h000, 7'd0},
    {OP_CLEAR, 4'd4,  9'h000, 7'd0},
    {OP_READ,  4'd3,  9'h000, 7'd0},
    {OP_READ,  4'd7,  9'h000, 7'd0},
    {OP_CLEAR, 4'd15, 9'h000, 7'd0},   // R5
    {OP_READ,  4'd7,  9'h000, 7'd0},
    {OP_READ,  4'd0,  9'h000, 7'd0},
    {OP_READ,  4'd15, 9'h000, 7'd0}
  };

  logic        clk;
  logic        rst_n;
  logic        init_z;
  logic        cmd_valid;
  logic        stn_sel;
  logic [3:0]  sub_addr;
  logic [4:0]  func;
  logic        trig_in;
  logic [7:0]  plane_in;
  logic [15:0] rd_data;
  logic        q_resp;

  int n_checks;
  int n_fail;
  logic        m_en;
  logic [23:0] m_trig;
  logic [15:0] m_plane [8];
  logic [15:0] got_data;
  logic        got_q;

  trig_scaler_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_z    (init_z),
    .cmd_valid (cmd_valid),
    .stn_sel   (stn_sel),
    .sub_addr  (sub_addr),
    .func      (func),
    .trig_in   (trig_in),
    .plane_in  (plane_in),
    .rd_data   (rd_data),
    .q_resp    (q_resp)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_word(input logic [3:0] a);
    if (a < 4'd8)  return m_plane[a[2:0]];
    if (a == 4'd14) return m_trig[15:0];
    if (a == 4'd15) return {8'h00, m_trig[23:16]};
    return 16'h0;
  endfunction

  task automatic model_reset();
    m_en = 1'b0;
    m_trig = '0;
    for (int i = 0; i < 8; i++) m_plane[i] = '0;
  endtask

  task automatic model_step(input logic [8:0] mask);
    if (m_en) begin
      if (mask[8]) m_trig = m_trig + 24'd1;
      for (int i = 0; i < 8; i++) if (mask[i]) m_plane[i] = m_plane[i] + 16'd1;
    end
  endtask

  task automatic model_clear(input logic [3:0] a);
    if (a == 4'd0 || a == 4'd15) m_trig = '0;
    for (int i = 0; i < 8; i++)
      if (a == 4'(i + 1) || a == 4'd15) m_plane[i] = '0;
  endtask

  task automatic do_cmd(input logic [3:0] a, input logic [4:0] f, input logic n);
    @(negedge clk);
    cmd_valid = 1'b1;
    stn_sel   = n;
    sub_addr  = a;
    func      = f;
    #1;
    got_data = rd_data;
    got_q    = q_resp;
    @(negedge clk);
    cmd_valid = 1'b0;
    stn_sel   = 1'b0;
  endtask

  task automatic read_chk(input logic [3:0] a, input string req);
    logic [15:0] e;
    e = model_word(a);
    do_cmd(a, 5'd2, 1'b1);
    check(got_data == e, req, got_data, e);
    check(got_q == 1'b1, {req, " Q"}, got_q, 1);
  endtask

  task automatic pulse(input logic [8:0] mask);
    @(negedge clk);
    trig_in  = mask[8];
    plane_in = mask[7:0];
    @(negedge clk);
    trig_in  = 1'b0;
    plane_in = '0;
    model_step(mask);
  endtask

  task automatic hold(input logic [8:0] mask, input int cyc);
    @(negedge clk);
    trig_in  = mask[8];
    plane_in = mask[7:0];
    repeat (cyc) @(negedge clk);
    trig_in  = 1'b0;
    plane_in = '0;
    model_step(mask);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fail = 0;
    init_z = 1'b0;
    cmd_valid = 1'b0;
    stn_sel = 1'b0;
    sub_addr = '0;
    func = '0;
    trig_in = 1'b0;
    plane_in = '0;
    model_reset();
    apply_reset();

    // reset state, R7 and R10
    #1;
    check(q_resp == 1'b0 && rd_data == 16'h0, "R10 idle outputs", {q_resp, rd_data}, 0);
    read_chk(4'd14, "R7 reset trig lo");
    read_chk(4'd15, "R7 reset trig hi");
    for (int a = 0; a < 8; a++) read_chk(4'(a), "R7 reset plane");

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] op;
      logic [3:0] a;
      logic [8:0] m;
      logic [6:0] r;
      {op, a, m, r} = VEC[v];
      case (op)
        OP_PULSE: for (int k = 0; k < int'(r); k++) pulse(m);
        OP_HOLD:  hold(m, int'(r));
        OP_CLEAR: begin
          do_cmd(a, 5'd11, 1'b1);
          model_clear(a);
          check(got_q, "R4 clear Q", got_q, 1);
        end
        OP_ENAB: begin
          do_cmd(a, 5'd17, 1'b1);
          m_en = 1'b1;
          check(got_q, "R6 enable Q", got_q, 1);
        end
        default: read_chk(a, "R1 R2 R3 R4 R5 R6 table read");
      endcase
    end

    // station select low: no read, no clear (R10)
    for (int k = 0; k < 3; k++) pulse(9'h1FF);
    do_cmd(4'd0, 5'd2, 1'b0);
    check(got_q == 1'b0 && got_data == 16'h0, "R10 unselected read", {got_q, got_data}, 0);
    do_cmd(4'd15, 5'd11, 1'b0);
    read_chk(4'd0, "R10 unselected clear ignored");
    read_chk(4'd14, "R10 unselected clear ignored trig");
    do_cmd(4'd9, 5'd2, 1'b1);
    check(got_q == 1'b0, "R10 unrecognised read Q", got_q, 0);

    // clear and counted edge in the same cycle (R9)
    @(negedge clk);
    trig_in   = 1'b1;
    cmd_valid = 1'b1;
    stn_sel   = 1'b1;
    sub_addr  = 4'd0;
    func      = 5'd11;
    @(negedge clk);
    cmd_valid = 1'b0;
    stn_sel   = 1'b0;
    trig_in   = 1'b0;
    m_trig    = '0;
    read_chk(4'd14, "R9 clear beats step");

    // overflow (R8) with carry into trigger high word
    do_cmd(4'd15, 5'd11, 1'b1);
    model_clear(4'd15);
    for (int k = 0; k < 65536; k++) pulse(9'h1FF);
    for (int a = 0; a < 8; a++) read_chk(4'(a), "R8 plane wrap");
    read_chk(4'd14, "R8 trig low carry");
    read_chk(4'd15, "R8 trig high carry");
    check(m_trig == 24'h010000, "R8 model sanity", m_trig, 24'h010000);

    // crate initialise (R7), enable dropped afterwards (R6)
    @(negedge clk);
    init_z = 1'b1;
    @(negedge clk);
    init_z = 1'b0;
    model_reset();
    read_chk(4'd15, "R7 init clears trig hi");
    read_chk(4'd5, "R7 init clears plane");
    pulse(9'h1FF);
    read_chk(4'd14, "R6 off after init");

    // asynchronous reset mid-run (R7)
    do_cmd(4'd5, 5'd17, 1'b1);
    m_en = 1'b1;
    pulse(9'h101);
    read_chk(4'd0, "R1 count after reenable");
    apply_reset();
    read_chk(4'd0, "R7 reset clears plane");
    read_chk(4'd14, "R7 reset clears trig");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule